// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in ordinary memory. A single base register names the page frame that holds the top-level table; an operating system reloads only this register on a context switch. For each translation the walker reads one top-level entry. That entry names the frame of a second-level table. It then reads one second-level entry, which names the frame of the target page. The result is that frame number joined to the 12-bit page offset.

The virtual address is split, from most to least significant, into a 10-bit top-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit offset (bits 11:0). Each table holds 1024 entries of 4 bytes, so one table fills exactly one 4 KB frame. An entry is valid when its bit 31 is set, and its bits 19:0 carry a frame number. An entry with bit 31 clear ends the walk with a page-fault response that says which level faulted. Only one translation is handled at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_rd_valid are 0. The base register holds frame 0.
- R2: The first memory read of a walk uses address {base_frame, 12'h000} + 4 * vaddr[31:22].
- R3: The second memory read uses address {top_entry[19:0], 12'h000} + 4 * vaddr[21:12].
- R4: When both entries have bit 31 set, the response carries rsp_fault = 0 and rsp_paddr = {second_entry[19:0], vaddr[11:0]}. Entry bits 30:20 have no effect on any address or result.
- R5: A top-level entry with bit 31 clear gives rsp_fault = 1, rsp_fault_lvl = 0 and rsp_paddr = 0, after exactly one memory read.
- R6: A second-level entry with bit 31 clear gives rsp_fault = 1, rsp_fault_lvl = 1 and rsp_paddr = 0, after exactly two memory reads.
- R7: A walk issues one read per level, and a read is never issued while an earlier answer is outstanding. mem_rd_valid and mem_rd_addr hold steady until mem_rd_ready accepts the read.
- R8: req_ready goes low in the cycle after a request is accepted. It stays low until the response has been taken.
- R9: While rsp_valid is high and rsp_ready is low, the response fields hold their values.
- R10: A base-register write made while a walk is active does not change that walk. The next request uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_wr_en | input | 1 | Load the base register |
| root_wr_frame | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_lvl | output | 1 | Faulting level: 0 top, 1 second |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read from memory |

## Verification
The hardest case to reach from the ports is a base-register update that lands while a walk is still in progress. The stimulus forces it by holding the memory answer back with added latency and pulsing the base-register write one cycle after the request is accepted. The top-level read has then not returned. The bench next checks that the walk in progress used the old table and that the following walk reads the new one. Faults at each level are produced by a memory model whose present bits depend arithmetically on the frame and index. The index sweep therefore runs through both fault kinds under varied read latency, memory back-pressure and response stalls.

// File: rtl/pt_walker_pkg.sv
// Package: shared types for the two-level page table walker.
// Assumes exactly two table levels; the state encoding is local to the walker.
package pt_walker_pkg;

    // Walk sequencer states, one issue/wait pair per table level.
    typedef enum logic [2:0] {
        WS_IDLE     = 3'd0,
        WS_L1_ISSUE = 3'd1,
        WS_L1_WAIT  = 3'd2,
        WS_L2_ISSUE = 3'd3,
        WS_L2_WAIT  = 3'd4,
        WS_REPLY    = 3'd5
    } walk_state_e;

    // Number of table levels walked per translation.
    localparam int unsigned WALK_LEVELS = 2;

    // Fault level codes reported on the response.
    localparam logic FLT_TOP    = 1'b0;
    localparam logic FLT_SECOND = 1'b1;

endpackage

// File: rtl/pt_root_reg.sv
// Module: base register holding the frame number of the top-level table.
// Assumes writes come from a context-switch path; reset value is a parameter.
module pt_root_reg #(
    parameter int unsigned PFN_W   = 20,
    parameter logic [PFN_W-1:0] RST_FRAME = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PFN_W-1:0] wr_frame,
    output logic [PFN_W-1:0] root_frame
);

    // Load the base frame on a write; reset to the configured frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_frame <= RST_FRAME;
        end else if (wr_en) begin
            root_frame <= wr_frame;
        end
    end

endmodule

// File: rtl/pt_entry_addr.sv
// Module: byte address of one table entry from a table frame and an index.
// Assumes a table of 2**IDX_W entries of 2**ENT_SH bytes fits inside one page.
module pt_entry_addr #(
    parameter int unsigned PFN_W  = 20,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned ENT_SH = 2
) (
    input  logic [PFN_W-1:0]       table_frame,
    input  logic [IDX_W-1:0]       index,
    output logic [PFN_W+OFS_W-1:0] entry_addr
);

    localparam int unsigned PA_W = PFN_W + OFS_W;

    logic [PA_W-1:0] table_base;
    logic [PA_W-1:0] index_bytes;

    // Table base is the frame start; the index is scaled by the entry size.
    always_comb begin
        table_base  = {table_frame, {OFS_W{1'b0}}};
        index_bytes = PA_W'(index) << ENT_SH;
        entry_addr  = table_base + index_bytes;
    end

    // The scaled index must stay inside the page that holds the table.
    always_comb begin
        assert_entry_in_page_R2: assert (entry_addr[PA_W-1:OFS_W] == table_frame);
    end

endmodule

// File: rtl/pt_walk_fsm.sv
// Module: walk sequencer. It accepts one request, reads one entry per level
// through the memory port, and builds the physical address or a fault.
// Assumes memory returns exactly one answer per accepted read, in order.
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int unsigned PFN_W = 20,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFS_W = 12,
    parameter int unsigned ENT_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [PFN_W-1:0]                    root_frame,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [2*IDX_W+OFS_W-1:0]            req_vaddr,
    output logic                                rsp_valid,
    input  logic                                rsp_ready,
    output logic [PFN_W+OFS_W-1:0]              rsp_paddr,
    output logic                                rsp_fault,
    output logic                                rsp_fault_lvl,
    output logic                                mem_rd_valid,
    input  logic                                mem_rd_ready,
    output logic [PFN_W+OFS_W-1:0]              mem_rd_addr,
    input  logic                                mem_rsp_valid,
    input  logic [ENT_W-1:0]                    mem_rsp_data,
    output logic [WALK_LEVELS-1:0][PFN_W-1:0]   tbl_frame,
    output logic [WALK_LEVELS-1:0][IDX_W-1:0]   tbl_index,
    input  logic [WALK_LEVELS-1:0][PFN_W+OFS_W-1:0] ent_addr
);

    localparam int unsigned VA_W     = 2 * IDX_W + OFS_W;
    localparam int unsigned PA_W     = PFN_W + OFS_W;
    localparam int unsigned PRES_BIT = ENT_W - 1;

    walk_state_e                      state_q;
    logic [VA_W-1:0]                  vaddr_q;
    logic [WALK_LEVELS-1:0][PFN_W-1:0] frame_q;
    logic [PA_W-1:0]                  paddr_q;
    logic                             fault_q;
    logic                             flvl_q;

    logic                             ent_present;
    logic [PFN_W-1:0]                 ent_frame;
    logic                             unused_rsv;

    // Split the returned entry into its present flag and frame number.
    always_comb begin
        ent_present = mem_rsp_data[PRES_BIT];
        ent_frame   = mem_rsp_data[PFN_W-1:0];
        unused_rsv  = ^mem_rsp_data[PRES_BIT-1:PFN_W];
    end

    // Sequence the walk and capture the frames and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            vaddr_q <= '0;
            frame_q <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            flvl_q  <= FLT_TOP;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        vaddr_q    <= req_vaddr;
                        frame_q[0] <= root_frame;
                        state_q    <= WS_L1_ISSUE;
                    end
                end
                WS_L1_ISSUE: begin
                    if (mem_rd_ready) begin
                        state_q <= WS_L1_WAIT;
                    end
                end
                WS_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            paddr_q <= '0;
                            fault_q <= 1'b1;
                            flvl_q  <= FLT_TOP;
                            state_q <= WS_REPLY;
                        end else begin
                            frame_q[1] <= ent_frame;
                            state_q    <= WS_L2_ISSUE;
                        end
                    end
                end
                WS_L2_ISSUE: begin
                    if (mem_rd_ready) begin
                        state_q <= WS_L2_WAIT;
                    end
                end
                WS_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            paddr_q <= '0;
                            fault_q <= 1'b1;
                            flvl_q  <= FLT_SECOND;
                        end else begin
                            paddr_q <= {ent_frame, vaddr_q[OFS_W-1:0]};
                            fault_q <= 1'b0;
                            flvl_q  <= FLT_TOP;
                        end
                        state_q <= WS_REPLY;
                    end
                end
                WS_REPLY: begin
                    if (rsp_ready) begin
                        state_q <= WS_IDLE;
                    end
                end
                default: begin
                    state_q <= WS_IDLE;
                end
            endcase
        end
    end

    // Feed the per-level address units with table frames and indices.
    always_comb begin
        tbl_frame    = frame_q;
        tbl_index[0] = vaddr_q[VA_W-1 -: IDX_W];
        tbl_index[1] = vaddr_q[OFS_W +: IDX_W];
    end

    // Drive the handshakes and the memory read address from the state.
    always_comb begin
        req_ready     = (state_q == WS_IDLE);
        rsp_valid     = (state_q == WS_REPLY);
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
        rsp_fault_lvl = flvl_q;
        mem_rd_valid  = (state_q == WS_L1_ISSUE) || (state_q == WS_L2_ISSUE);
        mem_rd_addr   = (state_q == WS_L2_ISSUE) ? ent_addr[1] : ent_addr[0];
    end

    // R7: a pending read keeps its request and address until accepted.
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R7: no new read while an answer is awaited.
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_L1_WAIT || state_q == WS_L2_WAIT) |-> !mem_rd_valid);

    // R8: once a request is taken the walker reports busy.
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: a stalled response keeps its fields.
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_fault) && $stable(rsp_fault_lvl)));

    // R5/R6: a fault never carries an address.
    assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R10: the captured base frame stays fixed for the whole walk.
    assert_root_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WS_IDLE) |=> $stable(frame_q[0]));

endmodule

// File: rtl/pt_walker.sv
// Module: top of the two-level page table walker. It ties the base register,
// one entry-address unit per level and the walk sequencer together.
// Assumes 1K-entry tables of 4-byte entries that exactly fill one frame.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned PFN_W  = 20,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned ENT_W  = 32,
    parameter int unsigned ENT_SH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_wr_en,
    input  logic [19:0]       root_wr_frame,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);

    localparam int unsigned PA_W = PFN_W + OFS_W;

    logic [PFN_W-1:0]                     root_frame;
    logic [WALK_LEVELS-1:0][PFN_W-1:0]    tbl_frame;
    logic [WALK_LEVELS-1:0][IDX_W-1:0]    tbl_index;
    logic [WALK_LEVELS-1:0][PA_W-1:0]     ent_addr;

    pt_root_reg #(
        .PFN_W     (PFN_W),
        .RST_FRAME ('0)
    ) u_root (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (root_wr_en),
        .wr_frame   (root_wr_frame),
        .root_frame (root_frame)
    );

    // One entry-address unit per table level.
    for (genvar g = 0; g < WALK_LEVELS; g++) begin : g_level
        pt_entry_addr #(
            .PFN_W  (PFN_W),
            .IDX_W  (IDX_W),
            .OFS_W  (OFS_W),
            .ENT_SH (ENT_SH)
        ) u_ea (
            .table_frame (tbl_frame[g]),
            .index       (tbl_index[g]),
            .entry_addr  (ent_addr[g])
        );
    end

    pt_walk_fsm #(
        .PFN_W (PFN_W),
        .IDX_W (IDX_W),
        .OFS_W (OFS_W),
        .ENT_W (ENT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_frame    (root_frame),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_fault_lvl (rsp_fault_lvl),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tbl_frame     (tbl_frame),
        .tbl_index     (tbl_index),
        .ent_addr      (ent_addr)
    );

    // R1: the walker is idle and silent right after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_rd_valid));

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
// Bench: sweeps indices, offsets, base frames, latencies and stalls against an
// arithmetic memory model, and checks every walk against computed results.
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic [19:0] root_wr_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_lvl;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;
    int n_ok = 0, n_f1 = 0, n_f2 = 0;

    // memory model controls and log
    int          mem_lat = 0;
    bit          mem_stall = 1'b0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [2];
    bit          pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int          cyc = 0;

    logic [31:0] got_paddr;
    logic        got_fault;
    logic        got_lvl;

    always #4 clk = ~clk;

    pt_walker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_wr_en    (root_wr_en),
        .root_wr_frame (root_wr_frame),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_fault_lvl (rsp_fault_lvl),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory contents: top tables live in frames with bit 19 clear.
    function automatic logic [31:0] mem_entry(input logic [31:0] a);
        logic [19:0] f;
        logic [9:0]  i;
        logic        pres;
        logic [19:0] nf;
        f = a[31:12];
        i = a[11:2];
        if (!f[19]) begin
            pres = (int'(i) % 7) != 3;
            nf   = {1'b1, f[8:0], i};
        end else begin
            pres = ((int'(f[3:0]) + int'(i)) % 5) != 2;
            nf   = {i, f[9:0]} ^ 20'h5A5A5;
        end
        return {pres, 11'h555, nf};
    endfunction

    // Memory responder, driven away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
                mem_rd_ready = 1'b0;
            end else begin
                if (pend) begin
                    if (pend_cnt == 0) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_data  = mem_entry(pend_addr);
                        pend = 1'b0;
                    end else begin
                        pend_cnt--;
                    end
                end
                mem_rd_ready = mem_stall ? cyc[0] : 1'b1;
                if (mem_rd_valid && mem_rd_ready) begin
                    pend      = 1'b1;
                    pend_addr = mem_rd_addr;
                    pend_cnt  = mem_lat;
                    if (rd_cnt < 2) rd_log[rd_cnt] = mem_rd_addr;
                    rd_cnt++;
                end
            end
        end
    end

    task automatic write_root(input logic [19:0] f);
        @(negedge clk);
        root_wr_en = 1'b1;
        root_wr_frame = f;
        @(negedge clk);
        root_wr_en = 1'b0;
    endtask

    // One translation; optional base write mid-walk and response stall.
    task automatic run_walk(input logic [31:0] va, input int lat, input bit stall,
                            input bit hold, input bit mid_wr, input logic [19:0] mid_f);
        int guard;
        bit busy_ok;
        mem_lat = lat;
        mem_stall = stall;
        @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = '0;
        check(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
        if (mid_wr) begin
            root_wr_en = 1'b1;
            root_wr_frame = mid_f;
            @(negedge clk);
            root_wr_en = 1'b0;
        end
        guard = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && guard < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        check(busy_ok && rsp_valid, "R8 busy until response", 32'(busy_ok), 32'd1);
        got_paddr = rsp_paddr;
        got_fault = rsp_fault;
        got_lvl   = rsp_fault_lvl;
        if (hold) begin
            @(negedge clk);
            @(negedge clk);
            check(rsp_valid && rsp_paddr == got_paddr && rsp_fault == got_fault
                  && rsp_fault_lvl == got_lvl, "R9 stalled response held",
                  rsp_paddr, got_paddr);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, "R8 ready after response", 32'(req_ready), 32'd1);
    endtask

    // Walk and compare against values derived from the requirements.
    task automatic do_walk(input logic [19:0] root, input logic [31:0] va, input int lat,
                           input bit stall, input bit hold, input bit mid_wr,
                           input logic [19:0] mid_f);
        logic [31:0] a1, a2, e1, e2, exp_pa;
        int exp_rd;
        run_walk(va, lat, stall, hold, mid_wr, mid_f);
        a1 = {root, 12'h000} + 32'(va[31:22]) * 4;
        check(rd_log[0] == a1, "R2 top entry address", rd_log[0], a1);
        e1 = mem_entry(a1);
        if (!e1[31]) begin
            exp_rd = 1;
            n_f1++;
            check(got_fault && got_lvl == 1'b0 && got_paddr == 0,
                  "R5 top-level fault", {got_fault, got_lvl, got_paddr[29:0]}, 32'h8000_0000);
        end else begin
            exp_rd = 2;
            a2 = {e1[19:0], 12'h000} + 32'(va[21:12]) * 4;
            check(rd_log[1] == a2, "R3 second entry address", rd_log[1], a2);
            e2 = mem_entry(a2);
            if (!e2[31]) begin
                n_f2++;
                check(got_fault && got_lvl == 1'b1 && got_paddr == 0,
                      "R6 second-level fault", {got_fault, got_lvl, got_paddr[29:0]},
                      32'hC000_0000);
            end else begin
                n_ok++;
                exp_pa = {e2[19:0], va[11:0]};
                check(!got_fault && got_paddr == exp_pa, "R4 physical address",
                      got_paddr, exp_pa);
            end
        end
        check(rd_cnt == exp_rd, "R7 reads per walk", 32'(rd_cnt), 32'(exp_rd));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0] roots [3];
        roots[0] = 20'h00010;
        roots[1] = 20'h00ABC;
        roots[2] = 20'h7FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(!rsp_valid && !mem_rd_valid, "R1 reset outputs idle",
              {30'd0, rsp_valid, mem_rd_valid}, 32'd0);
        // R1: base register resets to frame 0
        do_walk(20'h00000, 32'h00C0_1234, 0, 1'b0, 1'b0, 1'b0, '0);

        for (int r = 0; r < 3; r++) begin
            write_root(roots[r]);
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 6; b++) begin
                    logic [9:0]  i1, i2;
                    logic [11:0] of;
                    i1 = (a == 15) ? 10'd1023 : 10'(a * 68);
                    i2 = (b == 0) ? 10'd0 : (b == 5) ? 10'd1023 : 10'(b * 201 + a);
                    of = (b == 0) ? 12'h000 : (b == 5) ? 12'hFFF : 12'(a * 257 + b);
                    do_walk(roots[r], {i1, i2, of}, (a + b) % 3, b[0], a[0], 1'b0, '0);
                end
            end
        end

        // R10: base write during a walk only affects the next walk
        write_root(20'h00010);
        do_walk(20'h00010, 32'h0040_2ABC, 2, 1'b1, 1'b0, 1'b1, 20'h00ABC);
        do_walk(20'h00ABC, 32'h0040_2ABC, 0, 1'b0, 1'b0, 1'b0, '0);
        check(rd_log[0] == {20'h00ABC, 12'h000} + 32'd4, "R10 new base on next walk",
              rd_log[0], {20'h00ABC, 12'h004});

        check(n_ok > 0, "R4 successful walks seen", n_ok, 32'd1);
        check(n_f1 > 0, "R5 top faults seen", n_f1, 32'd1);
        check(n_f2 > 0, "R6 second faults seen", n_f2, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule